// File: doc/BRIEF.md
# Scanout Line Address Generator

This block produces the framebuffer word address from which each scanline of the active picture is fetched. The address comes from three events that the display timing generator supplies: frame start, line start and line compare. A start-of-picture byte address and a line pitch are written through a small write port. The pitch is counted in 8-byte units. At each frame start the block loads the word-aligned part of the start address. It then steps by the pitch at each active line start. The two low bytes-within-word bits of the start address leave the block as a fine pan value for the pixel path.

A new start address takes effect only after vertical blanking has been seen. A scroll or page flip written during the visible picture therefore cannot tear the current frame. A line compare event forces the line address back to zero, which gives a split screen whose lower part shows the top of memory. If the compare line is placed at the display height, this reset never lands inside the picture. Address arithmetic is modulo the full byte address space.

Top module: `scan_addr_gen`

## Requirements
- R1: After synchronous reset the word address output, the pan output, the held start address and the pitch are all zero. The next active line start after reset does not advance the address.
- R2: A write with `wr_sel`=1 stores `wr_data[10:0]` as the pitch in 8-byte units. Bits above bit 10 are ignored. The new pitch applies from the next advancing line start.
- R3: A write with `wr_sel`=0 stores a pending 32-bit byte start address. The pending value is copied into the active start only in cycles in which `vblank` is high. A start write made outside blanking leaves both outputs unchanged.
- R4: A `frame_start` pulse makes `rd_word_addr` equal to the active start address shifted right by two (bits 1:0 dropped) one cycle later.
- R5: `pan` equals the active start address bits 1:0 multiplied by two (0, 2, 4 or 6), and it changes only in the cycle after a cycle with `vblank` high.
- R6: A `line_start` pulse with `vblank` low advances `rd_word_addr` by pitch×2 words (pitch×8 bytes) one cycle later. The exception is the first line start after reset, after `frame_start` or after `line_cmp`, which holds the address.
- R7: A `line_start` pulse while `vblank` is high leaves `rd_word_addr` unchanged.
- R8: A `line_cmp` pulse sets `rd_word_addr` to zero one cycle later. The following line start then holds that zero address as the first line.
- R9: In one cycle, `frame_start` takes priority over `line_cmp`, and `line_cmp` takes priority over `line_start`.
- R10: The byte address wraps modulo 2^32, so the word address wraps modulo 2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank | input | 1 | High during vertical blanking |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_start | input | 1 | One-cycle pulse at the start of each scanline |
| line_cmp | input | 1 | One-cycle pulse when the split-screen compare line is reached |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 start address, 1 pitch |
| wr_data | input | 32 | Write data |
| rd_word_addr | output | 30 | Current line base address in 32-bit words |
| pan | output | 3 | Byte pan value, start bits 1:0 times two |

## Verification
The bench uses the default widths: a 32-bit byte address and an 11-bit pitch. At these widths the largest pitch of 2047 units can be applied to a start address a few words below the top of memory. This drives the address across the wrap of R10 within a single line step. It also lets every one of the four pan values be reached. The same default build is used to test the R9 priority cases, blanked line starts, and a start write made during the visible picture.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  typedef enum logic {
    SEL_START = 1'b0,
    SEL_PITCH = 1'b1
  } wr_target_e;
endpackage

// File: rtl/scan_addr_regs.sv
module scan_addr_regs
  import scan_addr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PITCH_W    = 11,
  parameter int WORD_SHIFT = 2,
  localparam int PAN_W     = WORD_SHIFT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vblank,
  input  logic               wr_en,
  input  wr_target_e         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [ADDR_W-1:0]  act_start_o,
  output logic [PAN_W-1:0]   pan_o
);
  logic [ADDR_W-1:0]  pend_q;
  logic [ADDR_W-1:0]  act_q;
  logic [PITCH_W-1:0] pitch_q;

  // software-side copies, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      pitch_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_START) pend_q  <= wr_data;
      else                     pitch_q <= wr_data[PITCH_W-1:0];
    end
  end

  // start address used by scanout only changes inside blanking
  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (vblank) act_q <= pend_q;
  end

  assign pitch_o     = pitch_q;
  assign act_start_o = act_q;
  assign pan_o       = {act_q[WORD_SHIFT-1:0], 1'b0};
endmodule

// File: rtl/scan_row_ctr.sv
module scan_row_ctr #(
  parameter int WADDR_W = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vblank,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               line_cmp,
  input  logic [WADDR_W-1:0] load_word,
  input  logic [WADDR_W-1:0] step_word,
  output logic [WADDR_W-1:0] row_o,
  output logic               first_o
);
  logic [WADDR_W-1:0] row_q;
  logic               first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      first_q <= 1'b1;
    end else if (frame_start) begin
      row_q   <= load_word;
      first_q <= 1'b1;
    end else if (line_cmp) begin
      row_q   <= '0;
      first_q <= 1'b1;
    end else if (line_start && !vblank) begin
      if (first_q) first_q <= 1'b0;
      else         row_q   <= row_q + step_word;
    end
  end

  assign row_o   = row_q;
  assign first_o = first_q;
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_addr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PITCH_W     = 11,
  parameter int PITCH_SHIFT = 3,
  parameter int WORD_SHIFT  = 2,
  localparam int WADDR_W    = ADDR_W - WORD_SHIFT,
  localparam int PAN_W      = WORD_SHIFT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vblank,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               line_cmp,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic [WADDR_W-1:0] rd_word_addr,
  output logic [PAN_W-1:0]   pan
);
  logic [PITCH_W-1:0] pitch_val;
  logic [ADDR_W-1:0]  act_start;
  logic [WADDR_W-1:0] step_word;
  logic [WADDR_W-1:0] load_word;
  logic               first_line;

  scan_addr_regs #(
    .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .WORD_SHIFT(WORD_SHIFT)
  ) u_regs (
    .clk(clk), .rst(rst), .vblank(vblank),
    .wr_en(wr_en), .wr_sel(wr_target_e'(wr_sel)), .wr_data(wr_data),
    .pitch_o(pitch_val), .act_start_o(act_start), .pan_o(pan)
  );

  assign load_word = act_start[ADDR_W-1:WORD_SHIFT];

  // pitch unit to word unit conversion
  generate
    if (PITCH_SHIFT >= WORD_SHIFT) begin : g_step_up
      assign step_word = WADDR_W'(pitch_val) << (PITCH_SHIFT - WORD_SHIFT);
    end else begin : g_step_dn
      assign step_word = WADDR_W'(pitch_val) >> (WORD_SHIFT - PITCH_SHIFT);
    end
  endgenerate

  scan_row_ctr #(.WADDR_W(WADDR_W)) u_row (
    .clk(clk), .rst(rst), .vblank(vblank),
    .frame_start(frame_start), .line_start(line_start), .line_cmp(line_cmp),
    .load_word(load_word), .step_word(step_word),
    .row_o(rd_word_addr), .first_o(first_line)
  );
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ADDR_W      = 32,
  parameter int PITCH_W     = 11,
  parameter int PITCH_SHIFT = 3,
  parameter int WORD_SHIFT  = 2,
  localparam int WADDR_W    = ADDR_W - WORD_SHIFT,
  localparam int PAN_W      = WORD_SHIFT + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               vblank,
  input logic               frame_start,
  input logic               line_start,
  input logic               line_cmp,
  input logic [WADDR_W-1:0] rd_word_addr,
  input logic [PAN_W-1:0]   pan,
  input logic [PITCH_W-1:0] pitch_val,
  input logic [ADDR_W-1:0]  act_start,
  input logic               first_line
);
  logic [WADDR_W-1:0] act_word;
  logic [WADDR_W-1:0] exp_step;
  assign act_word = act_start[ADDR_W-1:WORD_SHIFT];
  assign exp_step = WADDR_W'(pitch_val) * WADDR_W'(1 << (PITCH_SHIFT - WORD_SHIFT));

  a_r4_frame_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> rd_word_addr == $past(act_word));

  a_r5_pan_blank_only: assert property (@(posedge clk) disable iff (rst)
    !vblank |=> $stable(pan));

  a_r6_line_advance: assert property (@(posedge clk) disable iff (rst)
    (line_start && !vblank && !frame_start && !line_cmp && !first_line)
    |=> rd_word_addr == $past(rd_word_addr) + $past(exp_step));

  a_r6_first_hold: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && !line_cmp && first_line) |=> $stable(rd_word_addr));

  a_r7_blank_hold: assert property (@(posedge clk) disable iff (rst)
    (line_start && vblank && !frame_start && !line_cmp) |=> $stable(rd_word_addr));

  a_r8_cmp_zero: assert property (@(posedge clk) disable iff (rst)
    (line_cmp && !frame_start) |=> (rd_word_addr == '0) && first_line);
endmodule

bind scan_addr_gen scan_addr_gen_chk #(
  .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .PITCH_SHIFT(PITCH_SHIFT), .WORD_SHIFT(WORD_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .vblank(vblank), .frame_start(frame_start),
  .line_start(line_start), .line_cmp(line_cmp), .rd_word_addr(rd_word_addr),
  .pan(pan), .pitch_val(pitch_val), .act_start(act_start), .first_line(first_line)
);

// File: tb/tb_scan_addr_gen.sv
`timescale 1ns/1ps
module tb_scan_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        vblank, frame_start, line_start, line_cmp;
  logic        wr_en, wr_sel;
  logic [31:0] wr_data;
  logic [29:0] rd_word_addr;
  logic [2:0]  pan;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scan_addr_gen dut (
    .clk(clk), .rst(rst), .vblank(vblank), .frame_start(frame_start),
    .line_start(line_start), .line_cmp(line_cmp), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_word_addr(rd_word_addr), .pan(pan)
  );

  localparam logic [2:0] OP_WSTART = 3'd0, OP_WPITCH = 3'd1, OP_FRAME = 3'd2,
                         OP_LINE = 3'd3, OP_VLINE = 3'd4, OP_CMP = 3'd5;
  localparam int NV = 20;
  // {op, data, expected word address, expected pan}
  localparam logic [67:0] VEC [0:NV-1] = '{
    {OP_WPITCH, 32'd160,       30'h0,        3'd0},  // R2
    {OP_WSTART, 32'h0000_1003, 30'h0,        3'd0},  // R3 no effect outside blanking
    {OP_LINE,   32'd0,         30'h0,        3'd0},  // R1 first line after reset holds
    {OP_LINE,   32'd0,         30'd320,      3'd0},  // R6
    {OP_FRAME,  32'd0,         30'h400,      3'd6},  // R4 R5
    {OP_LINE,   32'd0,         30'h400,      3'd6},  // R6 first hold
    {OP_LINE,   32'd0,         30'h540,      3'd6},  // R6
    {OP_VLINE,  32'd0,         30'h540,      3'd6},  // R7
    {OP_LINE,   32'd0,         30'h680,      3'd6},  // R6
    {OP_CMP,    32'd0,         30'h0,        3'd6},  // R8
    {OP_LINE,   32'd0,         30'h0,        3'd6},  // R8 hold after compare
    {OP_LINE,   32'd0,         30'h140,      3'd6},  // R6
    {OP_WSTART, 32'hFFFF_FFF6, 30'h140,      3'd6},  // R3
    {OP_FRAME,  32'd0,         30'h3FFF_FFFD,3'd4},  // R4 R5
    {OP_LINE,   32'd0,         30'h3FFF_FFFD,3'd4},  // R6
    {OP_WPITCH, 32'h0000_07FF, 30'h3FFF_FFFD,3'd4},  // R2 max pitch
    {OP_LINE,   32'd0,         30'h0000_0FFB,3'd4},  // R10 wrap
    {OP_WPITCH, 32'hFFFF_F805, 30'h0000_0FFB,3'd4},  // R2 upper bits ignored
    {OP_LINE,   32'd0,         30'h0000_1005,3'd4},  // R2 pitch 5
    {OP_WSTART, 32'h0000_2001, 30'h0000_1005,3'd4}   // R3
  };

  task automatic clear_in();
    vblank = 0; frame_start = 0; line_start = 0; line_cmp = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic check(string tag, logic [29:0] ea, logic [2:0] ep);
    nvec++;
    if (rd_word_addr !== ea || pan !== ep) begin
      nerr++;
      $display("FAIL %s: addr=%h pan=%0d expected addr=%h pan=%0d", tag, rd_word_addr, pan, ea, ep);
    end
  endtask

  task automatic do_frame();
    vblank = 1; step();
    vblank = 1; frame_start = 1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset", 30'h0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [31:0] d;
      string tag;
      op = VEC[i][67:65];
      d  = VEC[i][64:33];
      case (op)
        OP_WSTART: begin wr_en = 1; wr_sel = 0; wr_data = d; step(); tag = "R3"; end
        OP_WPITCH: begin wr_en = 1; wr_sel = 1; wr_data = d; step(); tag = "R2"; end
        OP_FRAME:  begin do_frame(); tag = "R4 R5"; end
        OP_LINE:   begin line_start = 1; step(); tag = "R6 R10"; end
        OP_VLINE:  begin vblank = 1; line_start = 1; step(); tag = "R7"; end
        default:   begin line_cmp = 1; step(); tag = "R8"; end
      endcase
      check(tag, VEC[i][32:3], VEC[i][2:0]);
    end

    // R9: all three events together in blanking -> frame load wins
    vblank = 1; step();
    check("R5 pan after blanking", 30'h1005, 3'd2);
    vblank = 1; frame_start = 1; line_cmp = 1; line_start = 1; step();
    check("R9 frame over compare", 30'h800, 3'd2);
    // R9: compare beats line start
    line_cmp = 1; line_start = 1; step();
    check("R9 compare over line", 30'h0, 3'd2);
    line_start = 1; step();
    check("R8 first hold", 30'h0, 3'd2);
    line_start = 1; step();
    check("R6 pitch 5", 30'd10, 3'd2);

    // R1: reset mid-run clears everything
    rst = 1; step(); rst = 1; step(); rst = 0;
    check("R1 reset outputs", 30'h0, 3'd0);
    line_start = 1; step();
    line_start = 1; step();
    check("R1 pitch cleared", 30'h0, 3'd0);
    do_frame();
    check("R1 start cleared", 30'h0, 3'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule